// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 39-bit virtual address into a 56-bit physical address. It walks a radix page table with three levels that lives in memory. A request carries the virtual address, the page number of the root table, the level at which the walk starts, and an incoming global flag. The walker then reads one 8-byte page table entry per level over a request/response memory port and classifies each entry. It follows pointer entries downward until it reaches a leaf or a fault.

A walk ends with a one-cycle `done` pulse. The pulse carries one of two things:
- a fault code: access error, invalid entry, permission denied, or misaligned superpage;
- a successful translation, together with the final entry, the address it was read from, the leaf level and the global flag gathered along the path.

The permission decision itself is made outside the block. The walker presents the low flag byte of the entry under examination and consumes a combinational `perm_ok`. Accessed/dirty bit updates and translation caching belong to other blocks.

Entry layout used throughout:
- Flags: bit 0 valid (V), bit 1 read (R), bit 2 write (W), bit 3 execute (X), bit 4 user (U), bit 5 global (G).
- Physical page number: bits [53:10], 44 bits.
- Virtual page number: bits [38:12] of the address. Level index i is VPN bits [9i+8:9i], that is address bits [12+9i+8:12+9i].

Top module: `ptw_walker`

## Requirements
- R1: After reset `done` and `mem_req_valid` are low and `req_ready` is high.
- R2: The first read of a walk is issued at address (root page number << 12) + (index of the start level << 3). A start level above 2 acts as 2.
- R3: An entry with V=1 and R=W=X=0 is a pointer. At level L>0 it causes exactly one further read at level L-1, at address (entry page number << 12) + (index L-1 << 3).
- R4: An entry with V=0, or with W=1 and R=0, ends the walk with fault code 1 (invalid). A pointer found at level 0 also gives code 1, with no further read.
- R5: An error response to any read ends the walk with fault code 0 (access).
- R6: For a leaf, `perm_flags` equals entry bits [7:0] while the response is presented. If `perm_ok` is low, the walk ends with fault code 2 (no permission). This check takes priority over the alignment check.
- R7: A leaf at level L>0 whose page number has any of its low 9·L bits set ends the walk with fault code 3 (misaligned).
- R8: A successful walk reports:
  - `res_paddr` = {leaf page number OR (VPN AND low 9·L bit mask), virtual bits [11:0]};
  - `res_level` = L;
  - `res_pte` = the leaf entry;
  - `res_pte_addr` = the address it was read from.
- R9: `res_global` is the OR of `req_global` and the G bit of every entry read in the walk.
- R10: Handshake and timing rules:
  - `done` is high for exactly one cycle per walk.
  - `req_ready` is high only when idle, and requests made while busy are ignored.
  - `mem_req_valid` with a stable address is held until `mem_req_ready`.
  - Any response latency is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_vaddr | input | 39 | Virtual address to translate |
| req_root_ppn | input | 44 | Page number of the root table |
| req_level | input | 2 | Start level (0..2; 3 acts as 2) |
| req_global | input | 1 | Incoming global state |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_data | input | 64 | Entry data |
| perm_flags | output | 8 | Flag byte of the entry under examination |
| perm_ok | input | 1 | External permission verdict for that leaf |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 2 | 0 access, 1 invalid, 2 no permission, 3 misaligned |
| res_paddr | output | 56 | Translated physical address |
| res_pte | output | 64 | Final entry read |
| res_pte_addr | output | 56 | Address of the final entry |
| res_level | output | 2 | Level of the final entry |
| res_global | output | 1 | Gathered global flag |

## Verification
The embedded properties watch several rules on every cycle:
- the completion pulse lasting a single cycle;
- a pending memory request keeping its address until accepted;
- each pointer step lowering the level by exactly one and issuing a new read;
- an error response or a bottom-level pointer turning into the right fault in the following cycle;
- every successful result keeping the page offset of the virtual address.

The directed scenarios show what the properties cannot:
- the exact entry addresses and the number of reads;
- superpage merging at both upper levels;
- each fault class, including permission taking priority over misalignment;
- the global flag being gathered;
- requests being ignored while a walk is in progress under memory back-pressure and latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W      = 39;
  localparam int PA_W      = 56;
  localparam int PTE_W     = 64;
  localparam int OFS_W     = 12;
  localparam int IDX_W     = 9;
  localparam int LEVELS    = 3;
  localparam int LVL_W     = $clog2(LEVELS);
  localparam int VPN_W     = IDX_W * LEVELS;
  localparam int PPN_W     = PA_W - OFS_W;
  localparam int PPN_LSB   = 10;
  localparam int ENTRY_SH  = 3;
  localparam int FLAG_W    = 8;

  typedef enum logic [1:0] {
    FLT_ACCESS   = 2'd0,
    FLT_INVALID  = 2'd1,
    FLT_PERM     = 2'd2,
    FLT_MISALIGN = 2'd3
  } fault_e;

  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } pte_flags_t;

  // Table index for a given level, taken from the virtual page number.
  function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va,
                                                   input logic [LVL_W-1:0] lvl);
    return va[OFS_W + IDX_W*int'(lvl) +: IDX_W];
  endfunction

  // Mask covering the page-number bits that a leaf at this level leaves to the VPN.
  function automatic logic [PPN_W-1:0] level_mask(input int lvl);
    return ~({PPN_W{1'b1}} << (IDX_W*lvl));
  endfunction

  function automatic logic [PPN_W-1:0] entry_ppn(input logic [PTE_W-1:0] pte);
    return pte[PPN_LSB +: PPN_W];
  endfunction
endpackage

// File: rtl/ptw_classify.sv
module ptw_classify
  import ptw_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [LVL_W-1:0]  level,
  output logic              is_bad,
  output logic              is_ptr,
  output logic              is_leaf,
  output logic              ptr_at_bottom,
  output logic              g_bit
);
  pte_flags_t f;

  always_comb begin
    f             = pte_flags_t'(flags);
    is_bad        = !f.v || (f.w && !f.r);
    is_ptr        = !is_bad && !f.r && !f.w && !f.x;
    is_leaf       = !is_bad && !is_ptr;
    ptr_at_bottom = is_ptr && (level == '0);
    g_bit         = f.g;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  entry_addr
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx        = level_index(vaddr, level);
    entry_addr = {base_ppn, {OFS_W{1'b0}}} + PA_W'({idx, {ENTRY_SH{1'b0}}});
  end
endmodule

// File: rtl/ptw_leaf_map.sv
module ptw_leaf_map
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0] leaf_ppn,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic             misaligned,
  output logic [PPN_W-1:0] phys_ppn
);
  logic [PPN_W-1:0] per_lvl [LEVELS];
  logic [PPN_W-1:0] mask;

  // One candidate mask per level; the live one is picked by the leaf level.
  for (genvar l = 0; l < LEVELS; l++) begin : g_mask
    assign per_lvl[l] = (int'(level) == l) ? level_mask(l) : '0;
  end

  always_comb begin
    mask = '0;
    for (int l = 0; l < LEVELS; l++) mask = mask | per_lvl[l];
    misaligned = |(leaf_ppn & mask);
    phys_ppn   = leaf_ppn | (PPN_W'(vpn) & mask);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PPN_W-1:0]   req_root_ppn,
  input  logic [LVL_W-1:0]   req_level,
  input  logic               req_global,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic               mem_rsp_err,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic [FLAG_W-1:0]  perm_flags,
  input  logic               perm_ok,
  output logic               done,
  output logic               fault,
  output logic [1:0]         fault_code,
  output logic [PA_W-1:0]    res_paddr,
  output logic [PTE_W-1:0]   res_pte,
  output logic [PA_W-1:0]    res_pte_addr,
  output logic [LVL_W-1:0]   res_level,
  output logic               res_global
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_e;

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

  state_e           state_q;
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             glob_q;

  logic             done_q, fault_q;
  fault_e           code_q;
  logic [PA_W-1:0]  paddr_q, pte_addr_q;
  logic [PTE_W-1:0] pte_q;
  logic [LVL_W-1:0] res_lvl_q;
  logic             res_glob_q;

  // Named internal events
  logic             accept_evt, rsp_take, descend_evt, finish_evt;
  logic             is_bad, is_ptr, is_leaf, ptr_at_bottom, g_bit;
  logic             misaligned;
  logic [PPN_W-1:0] phys_ppn;
  logic             glob_next;
  logic             fault_n;
  fault_e           code_n;
  logic [LVL_W-1:0] start_lvl;

  ptw_addr_gen u_addr (
    .base_ppn   (base_q),
    .vaddr      (va_q),
    .level      (lvl_q),
    .entry_addr (mem_req_addr)
  );

  ptw_classify u_cls (
    .flags         (mem_rsp_data[FLAG_W-1:0]),
    .level         (lvl_q),
    .is_bad        (is_bad),
    .is_ptr        (is_ptr),
    .is_leaf       (is_leaf),
    .ptr_at_bottom (ptr_at_bottom),
    .g_bit         (g_bit)
  );

  ptw_leaf_map u_map (
    .leaf_ppn   (entry_ppn(mem_rsp_data)),
    .vpn        (va_q[OFS_W +: VPN_W]),
    .level      (lvl_q),
    .misaligned (misaligned),
    .phys_ppn   (phys_ppn)
  );

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ISSUE);
  assign perm_flags    = mem_rsp_data[FLAG_W-1:0];

  assign accept_evt  = req_ready && req_valid;
  assign rsp_take    = (state_q == S_WAIT) && mem_rsp_valid;
  assign descend_evt = rsp_take && !mem_rsp_err && is_ptr && !ptr_at_bottom;
  assign finish_evt  = rsp_take && !descend_evt;
  assign glob_next   = glob_q | g_bit;
  assign start_lvl   = (req_level > TOP_LVL) ? TOP_LVL : req_level;

  // Outcome priority: error, invalid, bottom pointer, permission, alignment
  always_comb begin
    fault_n = 1'b1;
    code_n  = FLT_ACCESS;
    if (mem_rsp_err)           code_n = FLT_ACCESS;
    else if (is_bad)           code_n = FLT_INVALID;
    else if (ptr_at_bottom)    code_n = FLT_INVALID;
    else if (!perm_ok)         code_n = FLT_PERM;
    else if (misaligned)       code_n = FLT_MISALIGN;
    else                       fault_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      glob_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (accept_evt) begin
          va_q    <= req_vaddr;
          base_q  <= req_root_ppn;
          lvl_q   <= start_lvl;
          glob_q  <= req_global;
          state_q <= S_ISSUE;
        end
        S_ISSUE: if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: if (descend_evt) begin
          base_q  <= entry_ppn(mem_rsp_data);
          lvl_q   <= lvl_q - 1'b1;
          glob_q  <= glob_next;
          state_q <= S_ISSUE;
        end else if (finish_evt) begin
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      code_q     <= FLT_ACCESS;
      paddr_q    <= '0;
      pte_q      <= '0;
      pte_addr_q <= '0;
      res_lvl_q  <= '0;
      res_glob_q <= 1'b0;
    end else begin
      done_q <= finish_evt;
      if (finish_evt) begin
        fault_q    <= fault_n;
        code_q     <= code_n;
        paddr_q    <= {phys_ppn, va_q[OFS_W-1:0]};
        pte_q      <= mem_rsp_data;
        pte_addr_q <= mem_req_addr;
        res_lvl_q  <= lvl_q;
        res_glob_q <= glob_next;
      end
    end
  end

  assign done         = done_q;
  assign fault        = fault_q;
  assign fault_code   = code_q;
  assign res_paddr    = paddr_q;
  assign res_pte      = pte_q;
  assign res_pte_addr = pte_addr_q;
  assign res_level    = res_lvl_q;
  assign res_global   = res_glob_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_DESCEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    descend_evt |=> mem_req_valid && (lvl_q == $past(lvl_q) - 1'b1)); // R3
  AST_BOTTOM_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !mem_rsp_err && ptr_at_bottom |=> done && fault && (fault_code == 2'd1)); // R4
  AST_ERR_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && mem_rsp_err |=> done && fault && (fault_code == 2'd0)); // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> res_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]); // R8
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [38:0] req_vaddr = '0;
  logic [43:0] req_root_ppn = '0;
  logic [1:0]  req_level = '0;
  logic        req_global = 1'b0;
  logic        mem_req_valid, mem_req_ready;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic [7:0]  perm_flags;
  logic        perm_ok;
  logic        done, fault;
  logic [1:0]  fault_code;
  logic [55:0] res_paddr, res_pte_addr;
  logic [63:0] res_pte;
  logic [1:0]  res_level;
  logic        res_global;

  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08,
                         FU = 8'h10, FG = 8'h20, FA = 8'h40, FD = 8'h80;

  int checks = 0, failures = 0;
  int lat = 0, stall_cfg = 0, stall_ctr = 0;
  logic block_user = 1'b0;
  logic [63:0] pmem [logic [55:0]];
  logic [55:0] rd_log [0:255];
  int nreads = 0;
  logic busy = 1'b0;
  int cnt = 0;
  logic [55:0] cap = '0;

  logic        o_seen, o_fault, o_global;
  logic [1:0]  o_code, o_level;
  logic [55:0] o_paddr, o_pte_addr;
  logic [63:0] o_pte;

  always #4 clk = ~clk;

  ptw_walker uut (.*);

  assign perm_ok       = !(block_user && perm_flags[4]);
  assign mem_req_ready = (stall_ctr == 0);

  always @(posedge clk) begin
    if (!mem_req_valid) stall_ctr <= stall_cfg;
    else if (stall_ctr != 0) stall_ctr <= stall_ctr - 1;
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (busy) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_err   <= !pmem.exists(cap);
        mem_rsp_data  <= pmem.exists(cap) ? pmem[cap] : 64'hDEAD_BEEF_0BAD_F00D;
        busy          <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mem_req_valid && mem_req_ready) begin
      busy            <= 1'b1;
      cnt             <= lat;
      cap             <= mem_req_addr;
      rd_log[nreads]  <= mem_req_addr;
      nreads          <= nreads + 1;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b0, fl};
  endfunction

  function automatic logic [55:0] ent(input logic [43:0] ppn, input logic [8:0] idx);
    return {ppn, 12'h000} + {44'b0, idx, 3'b000};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    o_seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin
        o_seen = 1'b1; o_fault = fault; o_code = fault_code; o_paddr = res_paddr;
        o_pte = res_pte; o_pte_addr = res_pte_addr; o_level = res_level; o_global = res_global;
        break;
      end
      @(negedge clk);
    end
    chk("R10 done seen", {63'b0, o_seen}, 64'd1);
  endtask

  task automatic walk(input logic [38:0] va, input logic [43:0] root,
                      input logic [1:0] lvl, input logic g);
    @(negedge clk);
    req_vaddr = va; req_root_ppn = root; req_level = lvl; req_global = g;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
  endtask

  task automatic expect_fault(input string tag, input logic [1:0] code);
    chk({tag, " fault"}, {63'b0, o_fault}, 64'd1);
    chk({tag, " code"}, {62'b0, o_code}, {62'b0, code});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 done low", {63'b0, done}, 64'd0);
    chk("R1 ready high", {63'b0, req_ready}, 64'd1);
    chk("R1 mem idle", {63'b0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_full_walk();
    logic [8:0] v2, v1, v0;
    logic [38:0] va;
    int s;
    pmem.delete();
    v2 = 9'h0A5; v1 = 9'h13C; v0 = 9'h077;
    va = {v2, v1, v0, 12'hABC};
    pmem[ent(44'h80000, v2)] = mk_pte(44'h80001, FV | FG);
    pmem[ent(44'h80001, v1)] = mk_pte(44'h80002, FV);
    pmem[ent(44'h80002, v0)] = mk_pte(44'h12345, FV | FR | FW | FA | FD);
    s = nreads;
    walk(va, 44'h80000, 2'd2, 1'b0);
    chk("R2 first read", {8'b0, rd_log[s]}, {8'b0, ent(44'h80000, v2)});
    chk("R3 second read", {8'b0, rd_log[s+1]}, {8'b0, ent(44'h80001, v1)});
    chk("R3 third read", {8'b0, rd_log[s+2]}, {8'b0, ent(44'h80002, v0)});
    chk("R3 read count", 64'(nreads - s), 64'd3);
    chk("R8 no fault", {63'b0, o_fault}, 64'd0);
    chk("R8 paddr", {8'b0, o_paddr}, {8'b0, 44'h12345, 12'hABC});
    chk("R8 level", {62'b0, o_level}, 64'd0);
    chk("R8 pte", o_pte, mk_pte(44'h12345, FV | FR | FW | FA | FD));
    chk("R8 pte addr", {8'b0, o_pte_addr}, {8'b0, ent(44'h80002, v0)});
    chk("R9 global from pointer", {63'b0, o_global}, 64'd1);
  endtask

  task automatic t_superpages();
    logic [38:0] va;
    int s;
    pmem.delete();
    va = {9'd3, 9'd5, 9'h1F0, 12'h123};
    pmem[ent(44'h100, 9'd3)] = mk_pte(44'h101, FV);
    pmem[ent(44'h101, 9'd5)] = mk_pte(44'h40200, FV | FR | FX);
    walk(va, 44'h100, 2'd2, 1'b0);
    chk("R8 L1 no fault", {63'b0, o_fault}, 64'd0);
    chk("R8 L1 merge", {8'b0, o_paddr}, {8'b0, 44'h40200 | 44'h1F0, 12'h123});
    chk("R8 L1 level", {62'b0, o_level}, 64'd1);
    chk("R9 no G anywhere", {63'b0, o_global}, 64'd0);
    va = {9'd7, 9'h1AB, 9'h0CD, 12'h456};
    pmem[ent(44'h100, 9'd7)] = mk_pte(44'h40000, FV | FR | FG);
    s = nreads;
    walk(va, 44'h100, 2'd2, 1'b0);
    chk("R8 L2 no fault", {63'b0, o_fault}, 64'd0);
    chk("R8 L2 merge", {8'b0, o_paddr}, {8'b0, 44'h40000 | {26'b0, 9'h1AB, 9'h0CD}, 12'h456});
    chk("R8 L2 level", {62'b0, o_level}, 64'd2);
    chk("R9 G on leaf", {63'b0, o_global}, 64'd1);
    chk("R3 single read for L2 leaf", 64'(nreads - s), 64'd1);
    // start at level 1: first index taken from VPN[17:9]
    va = {9'd0, 9'd5, 9'h1F0, 12'h000};
    s = nreads;
    walk(va, 44'h101, 2'd1, 1'b1);
    chk("R2 start level 1 addr", {8'b0, rd_log[s]}, {8'b0, ent(44'h101, 9'd5)});
    chk("R9 incoming global", {63'b0, o_global}, 64'd1);
  endtask

  task automatic t_misaligned();
    pmem.delete();
    pmem[ent(44'h200, 9'd1)] = mk_pte(44'h201, FV);
    pmem[ent(44'h201, 9'd2)] = mk_pte(44'h40201, FV | FR);
    walk({9'd1, 9'd2, 9'd0, 12'h0}, 44'h200, 2'd2, 1'b0);
    expect_fault("R7 L1 low bit", 2'd3);
    pmem[ent(44'h200, 9'd4)] = mk_pte(44'h40200, FV | FR);
    walk({9'd4, 9'd0, 9'd0, 12'h0}, 44'h200, 2'd2, 1'b0);
    expect_fault("R7 L2 bit9", 2'd3);
  endtask

  task automatic t_perm();
    pmem.delete();
    block_user = 1'b1;
    pmem[ent(44'h300, 9'd9)] = mk_pte(44'h55, FV | FR | FU);
    walk({9'd0, 9'd0, 9'd9, 12'h0}, 44'h300, 2'd0, 1'b0);
    expect_fault("R6 user leaf", 2'd2);
    pmem[ent(44'h300, 9'd8)] = mk_pte(44'h40201, FV | FR | FU);
    walk({9'd0, 9'd8, 9'd0, 12'h0}, 44'h300, 2'd1, 1'b0);
    expect_fault("R6 perm before misalign", 2'd2);
    block_user = 1'b0;
    walk({9'd0, 9'd0, 9'd9, 12'h0}, 44'h300, 2'd0, 1'b0);
    chk("R6 allowed leaf", {63'b0, o_fault}, 64'd0);
  endtask

  task automatic t_invalid();
    int s;
    pmem.delete();
    pmem[ent(44'h400, 9'd1)] = mk_pte(44'h1, FR);
    walk({9'd1, 9'd0, 9'd0, 12'h0}, 44'h400, 2'd2, 1'b0);
    expect_fault("R4 V clear", 2'd1);
    pmem[ent(44'h400, 9'd2)] = mk_pte(44'h1, FV | FW);
    walk({9'd2, 9'd0, 9'd0, 12'h0}, 44'h400, 2'd2, 1'b0);
    expect_fault("R4 write-only", 2'd1);
    pmem[ent(44'h400, 9'd3)] = mk_pte(44'h401, FV);
    s = nreads;
    walk({9'd0, 9'd0, 9'd3, 12'h0}, 44'h400, 2'd0, 1'b0);
    expect_fault("R4 pointer at L0", 2'd1);
    chk("R4 no read after L0 pointer", 64'(nreads - s), 64'd1);
  endtask

  task automatic t_access();
    int s;
    pmem.delete();
    walk({9'd6, 9'd0, 9'd0, 12'h0}, 44'h500, 2'd2, 1'b0);
    expect_fault("R5 root miss", 2'd0);
    pmem[ent(44'h500, 9'd6)] = mk_pte(44'h777, FV);
    s = nreads;
    walk({9'd6, 9'd0, 9'd0, 12'h0}, 44'h500, 2'd2, 1'b0);
    expect_fault("R5 second level miss", 2'd0);
    chk("R5 two reads", 64'(nreads - s), 64'd2);
  endtask

  task automatic t_busy();
    logic [38:0] va;
    int s;
    pmem.delete();
    lat = 4; stall_cfg = 2;
    va = {9'd1, 9'd2, 9'd3, 12'h0F0};
    pmem[ent(44'h600, 9'd1)] = mk_pte(44'h601, FV);
    pmem[ent(44'h601, 9'd2)] = mk_pte(44'h602, FV);
    pmem[ent(44'h602, 9'd3)] = mk_pte(44'hABCDE, FV | FR);
    s = nreads;
    @(negedge clk);
    req_vaddr = va; req_root_ppn = 44'h600; req_level = 2'd2; req_global = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    chk("R10 ready low when busy", {63'b0, req_ready}, 64'd0);
    req_vaddr = {9'd9, 9'd9, 9'd9, 12'h0}; req_root_ppn = 44'h999;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk("R10 first walk kept", {8'b0, o_paddr}, {8'b0, 44'hABCDE, 12'h0F0});
    repeat (6) @(negedge clk);
    chk("R10 busy request ignored", 64'(nreads - s), 64'd3);
    chk("R10 single pulse", {63'b0, done}, 64'd0);
    lat = 0; stall_cfg = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_walk();
    t_superpages();
    t_misaligned();
    t_perm();
    t_invalid();
    t_access();
    t_busy();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule